// File: doc/BRIEF.md
# Trip/Reset Interlocked Indicator Controller

This block drives two indicator or relay outputs: `green` means the system is armed and healthy, and `red` means it has tripped. They come from two asynchronous contact inputs, a trip contact and a momentary arm push-button. Both inputs are synchronized to the clock and then debounced. The clean levels feed a two-flag state register. Each flag has its own set and clear equations. Trip always wins over arm, and the two flags can never be on together.

An active-high `init` input forces both outputs off at once, without waiting for a clock edge. Its release is synchronized, so the block comes out of init cleanly. After init the outputs stay dark until a qualifying input arrives. A trip lights red, whatever state the block is in. A press of the arm button lights green, but only while trip is inactive. If red is on, that press also moves the state from red to green. Both outputs are flops, so no combinational path runs from any input to `green` or `red`.

Top module: `trip_interlock`

## Requirements
- R1: While `init` is high, both `green` and `red` are 0 within one nanosecond of its rise, without waiting for a clock edge. After `init` falls, both stay 0 until a debounced trip or arm input arrives.
- R2: When the debounced arm input is 1 and the debounced trip input is 0, the next state is green=1, red=0.
- R3: When the debounced trip input is 1, the next state is red=1, green=0. This holds even if arm is pressed in the same cycle.
- R4: An arm press while trip is active changes nothing: red stays 1 and green stays 0.
- R5: Once trip has gone inactive, an arm press moves the state from red=1 to green=1, red=0 in a single clock edge.
- R6: `green` and `red` are never 1 at the same time. If both flags were ever found set, each would be cleared.
- R7: While both debounced inputs are 0, the state holds. Releasing trip alone leaves red on.
- R8: A raw input reaches the state logic only after it has held a new level for 2**DEB_BITS consecutive cycles after synchronization. A trip or arm pulse of 4 cycles with DEB_BITS=3 has no effect, while a level held for 30 cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| init | input | 1 | Active-high init; asserts asynchronously, releases synchronously |
| trip_in | input | 1 | Raw trip contact, active high, asynchronous |
| arm_in | input | 1 | Raw momentary arm button, active high, asynchronous |
| green | output | 1 | Armed indicator, registered |
| red | output | 1 | Tripped indicator, registered |

## Verification
The bench presses arm while trip is held and presses both in the same cycle. A design with the wrong priority would light green there, or would briefly show both outputs on. It releases trip alone and expects red to stay lit. A design that treated trip as a level-follower would drop to dark or green instead. It also fires short glitches on both inputs, which a missing or miscounted debounce would turn into a state change. Finally, it raises init in the middle of a run and expects the outputs off before the next clock edge, and expects them to stay off after release.

// File: rtl/il_pkg.sv
package il_pkg;

  typedef struct packed {
    logic green;
    logic red;
  } lamp_t;

  // Next-state arithmetic of the two coupled flags.
  function automatic lamp_t lamp_next(lamp_t cur, logic trip, logic arm);
    logic g_set, g_clr, r_set, r_clr;
    lamp_t nx;
    g_set = ~trip & arm & ~cur.green;
    g_clr = (trip & cur.green) | (cur.green & cur.red);
    r_set = trip & ~cur.red;
    r_clr = (~trip & arm & cur.red) | (cur.green & cur.red);
    nx = cur;
    if (g_clr)      nx.green = 1'b0;
    else if (g_set) nx.green = 1'b1;
    if (r_clr)      nx.red = 1'b0;
    else if (r_set) nx.red = 1'b1;
    return nx;
  endfunction

endpackage

// File: rtl/il_init_sync.sv
module il_init_sync (
  input  logic clk,
  input  logic init,
  output logic run
);
  logic [1:0] sh;

  always_ff @(posedge clk or posedge init) begin
    if (init) sh <= 2'b00;
    else      sh <= {sh[0], 1'b1};
  end

  assign run = sh[1];
endmodule

// File: rtl/il_sync.sv
module il_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic run,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge run) begin
    if (!run) sh <= '0;
    else      sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/il_debounce.sv
module il_debounce #(
  parameter int DEB_BITS = 16,
  parameter bit DEB_EN   = 1'b1
) (
  input  logic clk,
  input  logic run,
  input  logic d,
  output logic q
);
  generate
    if (DEB_EN) begin : g_filter
      localparam logic [DEB_BITS-1:0] CMAX = {DEB_BITS{1'b1}};
      logic [DEB_BITS-1:0] cnt;
      logic                lvl;
      logic                differs;

      assign differs = (d != lvl);

      always_ff @(posedge clk or negedge run) begin
        if (!run) begin
          lvl <= 1'b0;
          cnt <= '0;
        end else if (!differs) begin
          cnt <= '0;
        end else if (cnt == CMAX) begin
          lvl <= d;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign q = lvl;

      // R8: a filtered level never moves while the input agrees with it
      a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!run)
        !differs |=> $stable(lvl));
      // R8: a change is only taken after the counter has run out
      a_r8_full_count: assert property (@(posedge clk) disable iff (!run)
        (differs && cnt != CMAX) |=> $stable(lvl));
    end else begin : g_bypass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/il_core.sv
module il_core
  import il_pkg::*;
(
  input  logic clk,
  input  logic run,
  input  logic trip_d,
  input  logic arm_d,
  output logic green,
  output logic red
);
  lamp_t st, nx;

  // Named events for the checks
  logic trip_evt, arm_ok, idle;
  assign trip_evt = trip_d;
  assign arm_ok   = arm_d & ~trip_d;
  assign idle     = ~trip_d & ~arm_d;

  assign nx = lamp_next(st, trip_d, arm_d);

  always_ff @(posedge clk or negedge run) begin
    if (!run) st <= '0;
    else      st <= nx;
  end

  assign green = st.green;
  assign red   = st.red;

  a_r1_init_dark: assert property (@(posedge clk)
    !run |-> (!green && !red));
  a_r2_arm_greens: assert property (@(posedge clk) disable iff (!run)
    arm_ok |=> (green && !red));
  a_r3_trip_reds: assert property (@(posedge clk) disable iff (!run)
    trip_evt |=> (red && !green));
  a_r4_arm_blocked: assert property (@(posedge clk) disable iff (!run)
    (trip_evt && arm_d && red) |=> red);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!run)
    !(green && red));
  a_r7_hold: assert property (@(posedge clk) disable iff (!run)
    idle |=> ($stable(green) && $stable(red)));
endmodule

// File: rtl/trip_interlock.sv
module trip_interlock #(
  parameter int DEB_BITS    = 16,
  parameter bit DEB_EN      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic init,
  input  logic trip_in,
  input  logic arm_in,
  output logic green,
  output logic red
);
  localparam int NIN = 2;

  logic           run;
  logic [NIN-1:0] raw, synced, clean;

  assign raw = {arm_in, trip_in};

  il_init_sync u_init (.clk(clk), .init(init), .run(run));

  for (genvar i = 0; i < NIN; i++) begin : g_in
    il_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .run(run), .d(raw[i]), .q(synced[i]));
    il_debounce #(.DEB_BITS(DEB_BITS), .DEB_EN(DEB_EN)) u_deb (
      .clk(clk), .run(run), .d(synced[i]), .q(clean[i]));
  end

  il_core u_core (
    .clk(clk), .run(run), .trip_d(clean[0]), .arm_d(clean[1]),
    .green(green), .red(red));
endmodule

// File: tb/test_trip_interlock.sv
module test_trip_interlock;
  logic clk = 1'b0;
  logic init = 1'b0;
  logic trip_in = 1'b0;
  logic arm_in = 1'b0;
  logic green, red;

  int checks = 0;
  int fails = 0;
  int excl_bad = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  trip_interlock #(.DEB_BITS(3)) i_trip_interlock (
    .clk(clk), .init(init), .trip_in(trip_in), .arm_in(arm_in),
    .green(green), .red(red));

  // Monitor: pops expected {green,red} and compares
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({green, red} !== e) begin
          fails++;
          $display("FAIL %s: got green=%b red=%b, expected green=%b red=%b",
                   t, green, red, e[1], e[0]);
        end
      end
    end
  end

  // R6 every-cycle watch
  always @(negedge clk) if (init == 1'b0 && green === 1'b1 && red === 1'b1) excl_bad++;

  task automatic expect_now(logic g, logic r, string t);
    exp_q.push_back({g, r});
    tag_q.push_back(t);
    #1;
  endtask

  task automatic step(logic t, logic a, int n, logic g, logic r, string tg);
    trip_in = t;
    arm_in  = a;
    repeat (n) @(negedge clk);
    expect_now(g, r, tg);
  endtask

  task automatic finish_up();
    checks++;
    if (excl_bad != 0) begin
      fails++;
      $display("FAIL R6: both outputs high in %0d cycles, expected 0", excl_bad);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2 init = 1'b1;
    repeat (5) @(negedge clk);
    expect_now(1'b0, 1'b0, "R1 dark during init");
    init = 1'b0;
    step(1'b0, 1'b0, 30, 1'b0, 1'b0, "R1 dark after release");
    // R8: short trip glitch ignored
    step(1'b1, 1'b0, 4, 1'b0, 1'b0, "R8 trip glitch pending");
    step(1'b0, 1'b0, 30, 1'b0, 1'b0, "R8 trip glitch ignored");
    // R2: arm while trip inactive
    step(1'b0, 1'b1, 30, 1'b1, 1'b0, "R2 arm greens");
    step(1'b0, 1'b0, 30, 1'b1, 1'b0, "R7 green holds");
    // R3: trip
    step(1'b1, 1'b0, 30, 1'b0, 1'b1, "R3 trip reds");
    // R4: arm during trip
    step(1'b1, 1'b1, 30, 1'b0, 1'b1, "R4 arm during trip");
    step(1'b1, 1'b0, 30, 1'b0, 1'b1, "R4 arm release during trip");
    // R7: trip release alone
    step(1'b0, 1'b0, 30, 1'b0, 1'b1, "R7 red holds after trip release");
    // R5: arm moves red to green
    step(1'b0, 1'b1, 30, 1'b1, 1'b0, "R5 red to green");
    step(1'b0, 1'b0, 30, 1'b1, 1'b0, "R7 green holds again");
    // R3: trip and arm together from green
    step(1'b1, 1'b1, 30, 1'b0, 1'b1, "R3 trip beats arm");
    step(1'b0, 1'b0, 30, 1'b0, 1'b1, "R7 red holds");
    step(1'b0, 1'b1, 30, 1'b1, 1'b0, "R5 rearm");
    arm_in = 1'b0;
    repeat (30) @(negedge clk);
    // R1: async init mid-run
    init = 1'b1;
    #1;
    expect_now(1'b0, 1'b0, "R1 async init clears");
    repeat (4) @(negedge clk);
    init = 1'b0;
    step(1'b0, 1'b0, 30, 1'b0, 1'b0, "R1 dark after second release");
    // R8: short arm glitch ignored, long one accepted
    step(1'b0, 1'b1, 4, 1'b0, 1'b0, "R8 arm glitch pending");
    step(1'b0, 1'b0, 30, 1'b0, 1'b0, "R8 arm glitch ignored");
    step(1'b0, 1'b1, 30, 1'b1, 1'b0, "R8 long arm accepted");
    step(1'b0, 1'b0, 10, 1'b1, 1'b0, "R7 final hold");
    wait (exp_q.size() == 0);
    #1;
    finish_up();
  end
endmodule